// File: doc/BRIEF.md
# Windowed Threshold Interrupt with Persistence Filter

This block watches a stream of 16-bit conversion results and decides when the measured level has stayed outside a programmed window long enough to alert the host. The window comes from two 8-bit threshold bytes. Each byte is the upper half of a 16-bit limit whose lower half is zero. A saturating counter tracks how many valid results in a row fell above the high limit or below the low limit. Once that run reaches the length selected by a 2-bit persistence code, a sticky flag is set and an active pull-down enable is driven for an open-drain interrupt pin.

The flag stays set until the host clears it. The host has two ways to do this: a dedicated clear strobe, or a write of 0 through the flag write path. The register file that holds the thresholds and the persistence code sits outside this block. It sends a strobe whenever the persistence code is rewritten, and that strobe restarts the run counter.

Top module: `win_irq_persist`

## Requirements
- R1: Limits are formed as high = {thr_hi, 8'h00} and low = {thr_lo, 8'h00}. A result is outside the window only if it is strictly greater than high or strictly less than low, so a value equal to either limit counts as inside.
- R2: The persistence code sets the required run length: 0 means 1 result, 1 means 4, 2 means 8 and 3 means 16 consecutive out-of-window results.
- R3: The flag rises on the clock edge that accepts the out-of-window valid result which brings the run to the required length, and not earlier.
- R4: Once set, the flag stays set through later results, whether in-window or out-of-window, until a clear occurs.
- R5: irq_pd is 1 exactly when the flag is 1 and 0 otherwise, so the open-drain interrupt pin is pulled low while the flag is set.
- R6: A clr_stb pulse clears the flag on the next edge. A flag_wr with flag_wdata = 0 also clears it. A flag_wr with flag_wdata = 1 has no effect.
- R7: A valid result inside the window resets the run count to zero.
- R8: The run count saturates at 16 and is not reset by a clear. A run that continues out of window therefore re-sets the flag on its next result.
- R9: A persist_wr pulse resets the run count to zero. A valid result that arrives in the same cycle is discarded.
- R10: When a trigger and a clear (clr_stb or flag_wr with 0) fall in the same cycle, the trigger wins and the flag stays set.
- R11: Inputs on res_data while res_valid is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | 16 | Conversion result |
| thr_hi | input | 8 | Upper limit, high byte |
| thr_lo | input | 8 | Lower limit, high byte |
| persist_code | input | 2 | Run-length select |
| persist_wr | input | 1 | Persistence code was rewritten |
| clr_stb | input | 1 | Clear-interrupt command |
| flag_wr | input | 1 | Host write to the flag bit |
| flag_wdata | input | 1 | Value written to the flag bit |
| flag | output | 1 | Sticky interrupt flag |
| irq_pd | output | 1 | Pull-down enable for the open-drain interrupt pin |

## Verification
A vector table with run length 1 exercises the window edges. It places values exactly on each limit, one count above the high limit and one below the low limit, and uses both the default full-open limits and a narrow window, so strict and inclusive comparisons produce different outcomes. Directed runs under each persistence code stop one result short of the required length and then add the final result, which separates the four run lengths. A run broken by a single in-window result shows that the count resets rather than holds. Further sequences cover clear-versus-trigger collisions, flag writes of 1 and 0, a persistence rewrite in the middle of a run, counter saturation, and results presented without the valid strobe.

// File: rtl/win_irq_persist.sv
module win_irq_persist #(
  parameter int DW = 16,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  input  logic [TW-1:0] thr_hi,
  input  logic [TW-1:0] thr_lo,
  input  logic [1:0]    persist_code,
  input  logic          persist_wr,
  input  logic          clr_stb,
  input  logic          flag_wr,
  input  logic          flag_wdata,
  output logic          flag,
  output logic          irq_pd
);
  localparam int LW   = DW - TW;
  localparam int CMAX = 16;
  localparam int CW   = $clog2(CMAX + 1);

  logic [DW-1:0] lim_hi, lim_lo;
  logic          outside, take, trig, clr_any;
  logic [CW-1:0] cnt, cnt_nxt, need;

  assign lim_hi  = {thr_hi, {LW{1'b0}}};
  assign lim_lo  = {thr_lo, {LW{1'b0}}};
  assign outside = (res_data > lim_hi) || (res_data < lim_lo);
  assign take    = res_valid && !persist_wr;

  always_comb begin
    case (persist_code)
      2'd0:    need = CW'(1);
      2'd1:    need = CW'(4);
      2'd2:    need = CW'(8);
      default: need = CW'(16);
    endcase
  end

  always_comb begin
    cnt_nxt = cnt;
    if (persist_wr)           cnt_nxt = '0;
    else if (res_valid)
      if (!outside)           cnt_nxt = '0;
      else if (cnt != CW'(CMAX)) cnt_nxt = cnt + 1'b1;
  end

  assign trig    = take && outside && (cnt_nxt >= need);
  assign clr_any = clr_stb || (flag_wr && !flag_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      if (trig)         flag <= 1'b1;
      else if (clr_any) flag <= 1'b0;
    end
  end

  assign irq_pd = flag;

  p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CMAX));
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr_stb && !(flag_wr && !flag_wdata) |=> flag);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb && !res_valid |=> !flag);
  p_rise_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(res_valid) && !$past(persist_wr));
  p_inwin_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !persist_wr && res_data <= lim_hi && res_data >= lim_lo |=> cnt == '0);
  p_pwr_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    persist_wr |=> cnt == '0);
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid && !persist_wr |=> $stable(cnt));
endmodule

// File: tb/test_win_irq_persist.sv
module test_win_irq_persist;
  logic clk = 1'b0, rst_n = 1'b0;
  logic res_valid = 1'b0, persist_wr = 1'b0, clr_stb = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
  logic [15:0] res_data = '0;
  logic [7:0] thr_hi = 8'hFF, thr_lo = 8'h00;
  logic [1:0] persist_code = 2'd0;
  logic flag, irq_pd;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  win_irq_persist i_win_irq_persist (
    .clk, .rst_n, .res_valid, .res_data, .thr_hi, .thr_lo, .persist_code,
    .persist_wr, .clr_stb, .flag_wr, .flag_wdata, .flag, .irq_pd);

  // {data, hi, lo, clr, expected flag}, run length 1
  localparam logic [33:0] VEC [0:11] = '{
    {16'h8000, 8'h80, 8'h10, 1'b0, 1'b0},
    {16'h1000, 8'h80, 8'h10, 1'b0, 1'b0},
    {16'h8001, 8'h80, 8'h10, 1'b0, 1'b1},
    {16'h5000, 8'h80, 8'h10, 1'b0, 1'b1},
    {16'h5000, 8'h80, 8'h10, 1'b1, 1'b0},
    {16'h0FFF, 8'h80, 8'h10, 1'b0, 1'b1},
    {16'h0FFF, 8'h80, 8'h10, 1'b1, 1'b1},
    {16'h4000, 8'h80, 8'h10, 1'b1, 1'b0},
    {16'hFF00, 8'hFF, 8'h00, 1'b0, 1'b0},
    {16'h0000, 8'hFF, 8'h00, 1'b0, 1'b0},
    {16'hFF01, 8'hFF, 8'h00, 1'b0, 1'b1},
    {16'hFF00, 8'hFF, 8'h00, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic exp);
    checks++;
    if (flag !== exp || irq_pd !== exp) begin
      failures++;
      $display("FAIL %s flag=%b irq_pd=%b expected=%b", req, flag, irq_pd, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, release strobes
  task automatic step(input logic v, input logic [15:0] d, input logic c,
                      input logic fw, input logic fd, input logic pw);
    res_valid = v; res_data = d; clr_stb = c; flag_wr = fw; flag_wdata = fd; persist_wr = pw;
    @(negedge clk);
    res_valid = 0; clr_stb = 0; flag_wr = 0; persist_wr = 0;
  endtask

  task automatic outs(input int n);
    for (int k = 0; k < n; k++) step(1, 16'hFFFF, 0, 0, 0, 0);
  endtask

  initial begin
    thr_hi = 8'h80; thr_lo = 8'h10;
    repeat (3) @(negedge clk);
    check("R5 reset", 1'b0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      thr_hi = VEC[i][17:10]; thr_lo = VEC[i][9:2];
      step(1, VEC[i][33:18], VEC[i][1], 0, 0, 0);
      check($sformatf("R1/R10 vector %0d", i), VEC[i][0]);
    end
    thr_hi = 8'h80; thr_lo = 8'h10;
    // R11: out-of-window data without valid
    step(0, 16'hFFFF, 0, 0, 0, 0); check("R11 no valid", 1'b0);
    // R2/R3: code 1 needs 4
    persist_code = 2'd1; step(0, 0, 0, 0, 0, 1);
    outs(3); check("R2 code1 three", 1'b0);
    outs(1); check("R3 code1 fourth", 1'b1);
    step(1, 16'h4000, 1, 0, 0, 0); check("R6 clr", 1'b0);
    // R7: broken run
    outs(3); step(1, 16'h4000, 0, 0, 0, 0); outs(3);
    check("R7 broken run", 1'b0);
    outs(1); check("R7 after restart", 1'b1);
    // R6 flag writes
    step(0, 0, 0, 1, 1, 0); check("R6 write1 keeps", 1'b1);
    step(1, 16'h4000, 0, 1, 0, 0); check("R6 write0 clears", 1'b0);
    step(0, 0, 0, 1, 1, 0); check("R6 write1 no effect", 1'b0);
    // R9: code 2 with rewrite mid run
    persist_code = 2'd2; step(0, 0, 0, 0, 0, 1);
    outs(7); check("R2 code2 seven", 1'b0);
    step(1, 16'hFFFF, 0, 0, 0, 1); check("R9 rewrite discards", 1'b0);
    outs(7); check("R9 seven after rewrite", 1'b0);
    outs(1); check("R2 code2 eighth", 1'b1);
    step(1, 16'h4000, 1, 0, 0, 0);
    // R8: code 3 and saturation
    persist_code = 2'd3; step(0, 0, 0, 0, 0, 1);
    outs(15); check("R2 code3 fifteen", 1'b0);
    outs(1); check("R2 code3 sixteenth", 1'b1);
    outs(5); check("R4 sticky", 1'b1);
    step(0, 0, 1, 0, 0, 0); check("R6 clr idle", 1'b0);
    outs(1); check("R8 saturated retrigger", 1'b1);
    step(1, 16'hFFFF, 0, 1, 0, 0); check("R10 write0 vs trigger", 1'b1);
    step(1, 16'h4000, 1, 0, 0, 0); check("R6 final clear", 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule